// File: doc/BRIEF.md
# Selectable Ratio Clock Divider

The block takes one fast base clock and produces, as registered square waves, a processor-side clock, a set of bus-side clocks, one free-running bus clock and one early bus clock. With the default 200 MHz base clock, the processor clock runs at 100 MHz or about 66.7 MHz. The bus clocks run at about 33.3 MHz at either speed. A quarter-rate mode divides every output by four more.

Two strap inputs choose the ratios: a speed select and an active-low quarter-rate select. Both are captured while reset is held and keep their values until the next reset. The early bus clock is the same waveform as the other bus clocks, moved ahead by a parameter number of base cycles.

Every output has its own enable, so that outside stop and power-down logic can hold the output low. The enable only takes effect between pulses. No output ever gives a shortened high phase, and no output ever begins part way through a high phase.

Top module: `ratio_clock_divider`

## Requirements
- R1: The `speed_hi` and `quarter_n` strap values are taken while `rst_n` is low and held after reset. Changing the pins after reset changes no output period.
- R2: With `speed_hi`=1 and `quarter_n`=1, `cpu_clk` has a period of 2 base cycles and stays high for 1.
- R3: With `speed_hi`=0 and `quarter_n`=1, `cpu_clk` has a period of 3 base cycles, high for 2 and low for 1.
- R4: With `quarter_n`=1, every bus clock (`pci_clk`, `pci_free_clk`, `pci_early_clk`) has a period of 6 base cycles and is high for 3, for either value of `speed_hi`.
- R5: With `quarter_n`=0, every ratio is four times longer. `cpu_clk` has a period of 8 (high 4) or 12 (high 6) base cycles, and the bus clocks have a period of 24 (high 12).
- R6: Every rising edge of an ungated bus clock falls in the same base cycle as a rising edge of `cpu_clk`.
- R7: `pci_early_clk` rises EARLY_LEAD base cycles (default 1) before the rising edge of the other bus clocks, and has the same period and high time.
- R8: When an enable is low, its output is held low. A stop only takes effect after a complete high phase, and a restart begins with a complete high phase.
- R9: `pci_free_clk` is controlled only by `free_en`. Clearing the `pci_en` bits does not stop it.
- R10: During reset every output is low. After reset the first high phase of each output is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Fast base clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| speed_hi | input | 1 | Speed strap: 1 selects the fast processor ratio |
| quarter_n | input | 1 | Quarter-rate strap, active low |
| cpu_en | input | 1 | Enable for cpu_clk |
| pci_en | input | N_PCI | Per-output enables for the gated bus clocks |
| early_en | input | 1 | Enable for pci_early_clk |
| free_en | input | 1 | Enable for pci_free_clk |
| cpu_clk | output | 1 | Processor-side clock |
| pci_clk | output | N_PCI | Gated bus clocks |
| pci_early_clk | output | 1 | Bus clock leading the others |
| pci_free_clk | output | 1 | Bus clock not controlled by the bus stop enables |

## Verification
The bench tries all four strap combinations. The two speed settings are told apart by the processor period (2 against 3) while the bus period stays fixed, and the two rate settings by the factor of four on every output. For each combination it measures the early-to-normal rising-edge distance, and it checks that every bus rising edge falls on a processor rising edge, which separates a divide-by-3 that stays in phase from one that drifts. Directed cases then drop and restore enables in the middle of long quarter-rate high phases, to check that the pulses keep their full width. They also toggle the strap pins after reset, to show that those pins no longer have any effect.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam int RW = 8;
   typedef logic [RW-1:0] ratio_t;
   typedef struct packed {
      ratio_t cpu_div;
      ratio_t pci_div;
   } ratio_set_t;
endpackage

// File: rtl/clkdiv_strap.sv
module clkdiv_strap
   import clkdiv_pkg::*;
#(
   parameter int CPU_DIV_FAST = 2,
   parameter int CPU_DIV_SLOW = 3,
   parameter int PCI_DIV      = 6,
   parameter int QUARTER_MULT = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       speed_hi,
   input  logic       quarter_n,
   output ratio_set_t ratios
);
   logic [1:0] strap_q;

   // Straps follow the pins only while reset is held.
   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= {speed_hi, quarter_n};
   end

   always_comb begin
      int cpu_base;
      int mult;
      cpu_base       = strap_q[1] ? CPU_DIV_FAST : CPU_DIV_SLOW;
      mult           = strap_q[0] ? 1 : QUARTER_MULT;
      ratios.cpu_div = ratio_t'(cpu_base * mult);
      ratios.pci_div = ratio_t'(PCI_DIV * mult);
   end

   p_strap_held_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(strap_q));
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
   import clkdiv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  ratio_set_t ratios,
   output ratio_t     cnt,
   output ratio_t     cpu_cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         cpu_cnt <= '0;
      end else begin
         cnt     <= (cnt == ratios.pci_div - ratio_t'(1)) ? '0 : cnt + ratio_t'(1);
         cpu_cnt <= (cpu_cnt == ratios.cpu_div - ratio_t'(1)) ? '0 : cpu_cnt + ratio_t'(1);
      end
   end

   p_phase_bound_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt < ratios.pci_div);
   p_cpu_pci_align_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> (cpu_cnt == '0));
endmodule

// File: rtl/clkdiv_gate_cell.sv
module clkdiv_gate_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic wave_raw,
   input  logic enable,
   output logic clk_out
);
   logic gate_q;
   logic ref_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q  <= 1'b0;
         ref_q   <= 1'b0;
         clk_out <= 1'b0;
      end else begin
         ref_q   <= wave_raw;
         clk_out <= wave_raw & gate_q;
         if (!wave_raw) gate_q <= enable;
      end
   end

   p_stop_full_high_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_out) |-> $fell(ref_q));
   p_start_full_high_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out) |-> $rose(ref_q));
endmodule

// File: rtl/ratio_clock_divider.sv
module ratio_clock_divider
   import clkdiv_pkg::*;
#(
   parameter int CPU_DIV_FAST = 2,
   parameter int CPU_DIV_SLOW = 3,
   parameter int PCI_DIV      = 6,
   parameter int QUARTER_MULT = 4,
   parameter int N_PCI        = 4,
   parameter int EARLY_LEAD   = 1
) (
   input  logic             clk_base,
   input  logic             rst_n,
   input  logic             speed_hi,
   input  logic             quarter_n,
   input  logic             cpu_en,
   input  logic [N_PCI-1:0] pci_en,
   input  logic             early_en,
   input  logic             free_en,
   output logic             cpu_clk,
   output logic [N_PCI-1:0] pci_clk,
   output logic             pci_early_clk,
   output logic             pci_free_clk
);
   localparam int           P_MAX  = PCI_DIV * QUARTER_MULT;
   localparam logic [RW:0]  LEAD_W = (RW+1)'(EARLY_LEAD);

   if (CPU_DIV_FAST < 2 || CPU_DIV_SLOW < 2) begin : g_bad_cpu
      $error("processor ratios must be at least 2");
   end
   if ((PCI_DIV % CPU_DIV_FAST) != 0 || (PCI_DIV % CPU_DIV_SLOW) != 0) begin : g_bad_mult
      $error("bus ratio must be a multiple of both processor ratios");
   end
   if (QUARTER_MULT < 1 || P_MAX >= (1 << RW)) begin : g_bad_range
      $error("longest ratio does not fit the counter width");
   end
   if (EARLY_LEAD < 1 || EARLY_LEAD >= PCI_DIV) begin : g_bad_lead
      $error("early lead must lie in 1 .. PCI_DIV-1");
   end
   if (N_PCI < 1) begin : g_bad_count
      $error("at least one gated bus clock is needed");
   end

   ratio_set_t  ratios;
   ratio_t      cnt, cpu_cnt;
   ratio_t      cpu_hi, pci_hi;
   logic [RW:0] ep_sum, ep;
   logic        cpu_raw, pci_raw, early_raw;

   clkdiv_strap #(
      .CPU_DIV_FAST(CPU_DIV_FAST), .CPU_DIV_SLOW(CPU_DIV_SLOW),
      .PCI_DIV(PCI_DIV), .QUARTER_MULT(QUARTER_MULT)
   ) i_strap (
      .clk(clk_base), .rst_n(rst_n), .speed_hi(speed_hi),
      .quarter_n(quarter_n), .ratios(ratios)
   );

   clkdiv_phase i_phase (
      .clk(clk_base), .rst_n(rst_n), .ratios(ratios),
      .cnt(cnt), .cpu_cnt(cpu_cnt)
   );

   // Odd processor ratios keep the longer half high.
   always_comb begin
      cpu_hi    = ratio_t'(((RW+1)'(ratios.cpu_div) + (RW+1)'(1)) >> 1);
      pci_hi    = ratios.pci_div >> 1;
      cpu_raw   = cpu_cnt < cpu_hi;
      pci_raw   = cnt < pci_hi;
      ep_sum    = {1'b0, cnt} + LEAD_W;
      ep        = (ep_sum >= {1'b0, ratios.pci_div}) ? ep_sum - {1'b0, ratios.pci_div} : ep_sum;
      early_raw = ep < {1'b0, pci_hi};
   end

   clkdiv_gate_cell i_cpu_cell (
      .clk(clk_base), .rst_n(rst_n), .wave_raw(cpu_raw),
      .enable(cpu_en), .clk_out(cpu_clk)
   );

   for (genvar i = 0; i < N_PCI; i++) begin : g_pci
      clkdiv_gate_cell i_cell (
         .clk(clk_base), .rst_n(rst_n), .wave_raw(pci_raw),
         .enable(pci_en[i]), .clk_out(pci_clk[i])
      );
   end

   clkdiv_gate_cell i_early_cell (
      .clk(clk_base), .rst_n(rst_n), .wave_raw(early_raw),
      .enable(early_en), .clk_out(pci_early_clk)
   );

   clkdiv_gate_cell i_free_cell (
      .clk(clk_base), .rst_n(rst_n), .wave_raw(pci_raw),
      .enable(free_en), .clk_out(pci_free_clk)
   );

   p_early_leads_r7 : assert property (@(posedge clk_base) disable iff (!rst_n)
      (cnt == ratios.pci_div - ratio_t'(EARLY_LEAD)) |-> early_raw && !pci_raw);
endmodule

// File: tb/test_ratio_clock_divider.sv
module test_ratio_clock_divider;
   localparam int N_PCI = 4;
   localparam int LEAD  = 1;

   localparam int V_SEL[4]  = '{1, 0, 1, 0};
   localparam int V_QN[4]   = '{1, 1, 0, 0};
   localparam int V_CPER[4] = '{2, 3, 8, 12};
   localparam int V_CHI[4]  = '{1, 2, 4, 6};
   localparam int V_PPER[4] = '{6, 6, 24, 24};
   localparam int V_PHI[4]  = '{3, 3, 12, 12};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic speed_hi = 1'b1, quarter_n = 1'b1;
   logic cpu_en = 1'b1, early_en = 1'b1, free_en = 1'b1;
   logic [N_PCI-1:0] pci_en = '1;
   logic cpu_clk, pci_early_clk, pci_free_clk;
   logic [N_PCI-1:0] pci_clk;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   ratio_clock_divider #(.N_PCI(N_PCI), .EARLY_LEAD(LEAD)) i_ratio_clock_divider (
      .clk_base(clk), .rst_n(rst_n), .speed_hi(speed_hi), .quarter_n(quarter_n),
      .cpu_en(cpu_en), .pci_en(pci_en), .early_en(early_en), .free_en(free_en),
      .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pci_early_clk(pci_early_clk),
      .pci_free_clk(pci_free_clk)
   );

   function automatic logic pick(int s);
      case (s)
         0:       return cpu_clk;
         1:       return pci_clk[0];
         2:       return pci_early_clk;
         3:       return pci_free_clk;
         default: return pci_clk[1];
      endcase
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_rise(int s);
      logic prv;
      @(negedge clk);
      prv = pick(s);
      for (int g = 0; g < 300; g++) begin
         @(negedge clk);
         if (!prv && pick(s)) break;
         prv = pick(s);
      end
   endtask

   task automatic measure(int s, output int hi, output int per);
      wait_rise(s);
      hi = 1;
      @(negedge clk);
      while (pick(s) && hi < 400) begin hi++; @(negedge clk); end
      per = hi;
      while (!pick(s) && per < 400) begin per++; @(negedge clk); end
   endtask

   task automatic do_reset(int sel, int qn);
      rst_n = 1'b0; speed_hi = sel[0]; quarter_n = qn[0];
      cpu_en = 1'b1; early_en = 1'b1; free_en = 1'b1; pci_en = '1;
      repeat (5) @(negedge clk);
      // R10: every output low during reset
      check({cpu_clk, pci_clk, pci_early_clk, pci_free_clk} == '0, "R10",
            "outputs in reset", int'({cpu_clk, pci_clk, pci_early_clk, pci_free_clk}), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int hi, per, n;
      logic pp, pc;
      bit bad;
      string ctag, ptag;

      for (int i = 0; i < 4; i++) begin
         ctag = (V_QN[i] == 0) ? "R5" : (V_SEL[i] == 1 ? "R2" : "R3");
         ptag = (V_QN[i] == 0) ? "R5" : "R4";
         do_reset(V_SEL[i], V_QN[i]);
         // R10: the first pulse after reset is complete
         measure(1, hi, per);
         check(hi == V_PHI[i], "R10", "first bus high", hi, V_PHI[i]);
         measure(0, hi, per);
         check(hi == V_CHI[i], ctag, "cpu high", hi, V_CHI[i]);
         check(per == V_CPER[i], ctag, "cpu period", per, V_CPER[i]);
         measure(4, hi, per);
         check(hi == V_PHI[i], ptag, "bus high", hi, V_PHI[i]);
         check(per == V_PPER[i], ptag, "bus period", per, V_PPER[i]);
         measure(3, hi, per);
         check(per == V_PPER[i], ptag, "free period", per, V_PPER[i]);
         measure(2, hi, per);
         check(hi == V_PHI[i] && per == V_PPER[i], "R7", "early high/period",
               hi * 100 + per, V_PHI[i] * 100 + V_PPER[i]);
         // R7: lead of the early clock
         wait_rise(2);
         n = 0; pp = pci_clk[2];
         for (int g = 0; g < 100; g++) begin
            @(negedge clk); n++;
            if (!pp && pci_clk[2]) break;
            pp = pci_clk[2];
         end
         check(n == LEAD, "R7", "early lead", n, LEAD);
         // R6: bus rising edges land on processor rising edges
         bad = 1'b0;
         @(negedge clk); pp = pci_clk[3]; pc = cpu_clk;
         for (int g = 0; g < 60; g++) begin
            @(negedge clk);
            if (!pp && pci_clk[3] && !(!pc && cpu_clk)) bad = 1'b1;
            pp = pci_clk[3]; pc = cpu_clk;
         end
         check(!bad, "R6", "edge alignment", int'(bad), 0);
         // R1: pins changed after reset have no effect
         speed_hi = ~speed_hi; quarter_n = ~quarter_n;
         repeat (30) @(negedge clk);
         measure(0, hi, per);
         check(per == V_CPER[i], "R1", "cpu period after pin change", per, V_CPER[i]);
         measure(4, hi, per);
         check(per == V_PPER[i], "R1", "bus period after pin change", per, V_PPER[i]);
      end

      // R8: stop in the middle of a long high phase, slow quarter mode
      do_reset(0, 0);
      wait_rise(1);
      hi = 1;
      repeat (3) begin @(negedge clk); if (pci_clk[0]) hi++; end
      pci_en[0] = 1'b0;
      @(negedge clk);
      while (pci_clk[0] && hi < 100) begin hi++; @(negedge clk); end
      check(hi == 12, "R8", "last high before stop", hi, 12);
      bad = 1'b0; n = 0; pp = pci_free_clk;
      for (int g = 0; g < 60; g++) begin
         @(negedge clk);
         if (pci_clk[0]) bad = 1'b1;
         if (!pp && pci_free_clk) n++;
         pp = pci_free_clk;
      end
      check(!bad, "R8", "stopped output high", int'(bad), 0);
      check(n >= 2, "R9", "free rises while bus stopped", n, 2);
      pci_en[0] = 1'b1;
      measure(1, hi, per);
      check(hi == 12 && per == 24, "R8", "restart pulse", hi * 100 + per, 1224);

      // R8: processor clock stopped part way through its high phase
      wait_rise(0);
      @(negedge clk);
      cpu_en = 1'b0;
      hi = 2;
      @(negedge clk);
      while (cpu_clk && hi < 100) begin hi++; @(negedge clk); end
      check(hi == 6, "R8", "cpu last high", hi, 6);
      bad = 1'b0;
      for (int g = 0; g < 40; g++) begin @(negedge clk); if (cpu_clk) bad = 1'b1; end
      check(!bad, "R8", "cpu held low", int'(bad), 0);
      cpu_en = 1'b1;
      measure(0, hi, per);
      check(hi == 6 && per == 12, "R8", "cpu restart", hi * 100 + per, 612);

      // R9: all bus enables cleared, free output keeps running
      pci_en = '0;
      measure(3, hi, per);
      check(hi == 12 && per == 24, "R9", "free with bus enables cleared",
            hi * 100 + per, 1224);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule